// File: doc/BRIEF.md
# I2C Single-Master Byte Controller

This block runs one I2C transaction per start pulse from a fast system clock. It generates SCL itself with a counter-based divider that can be switched off. While the divider is off, SCL rests high. SDA is driven as an open-drain line: the block only ever pulls it low or releases it.

A transaction runs as follows:
1. The block issues a START.
2. It sends the 7-bit target address followed by the direction bit.
3. It moves a programmed number of data bytes, either written or read.
4. It closes with a STOP.

The block finds SCL edges by comparing a registered SCL copy with its previous value. Every SDA change and every sample is placed a fixed number of divider counts after such an edge, so SDA never moves while SCL is high inside a byte.

Write bytes enter on a valid/ready port. Read bytes leave on a valid-only port, because SCL cannot be paused to wait for a consumer.

The write port follows these rules:
- A transfer happens on a clock edge where both `wr_valid` and `wr_ready` are high.
- `wr_ready` rises for exactly one cycle each time the engine needs the next byte.
- The source must already hold `wr_valid` high at that moment. There is no waiting, since the bus keeps clocking.

The read port has no back-pressure: `rd_valid` is a one-cycle pulse and the consumer must take every byte. The status outputs `busy`, `done` and `nack_err` are plain level or pulse signals.

Top module: `i2c_byte_master`

## Requirements
- R1: After reset, `scl_out` is 1, `sda_pull` is 0, and `busy`, `done` and `nack_err` are 0.
- R2: A transaction begins with SDA pulled low while SCL is high. The first falling edge of SCL then follows exactly START_HOLD+HALF system clocks after SDA falls.
- R3: While the bus clocks, every SCL high or low phase lasts exactly HALF system clocks. Outside a transaction SCL stays high.
- R4: In each transaction the bus shows exactly one START and exactly one STOP. SDA never changes while SCL is high, apart from those two conditions.
- R5: The first byte on the wire is the 7-bit address sent MSB first, followed by the direction bit (1 = read, 0 = write).
- R6: On a write with `xfer_len` = N, exactly N bytes are taken through the valid/ready port. They appear on the wire in order, each sent MSB first.
- R7: The block samples the ninth SCL high phase of an address or write byte. If SDA is high there, `nack_err` goes to 1, no further bytes move, and the block issues a STOP. `nack_err` holds until the next start.
- R8: On a read with `xfer_len` = N, the block releases SDA during data bits. For each received byte it pulses `rd_valid` once, with the byte assembled MSB first. It drives ACK (SDA low) on the ninth bit of every byte except the last, where it leaves SDA high (NACK).
- R9: The STOP releases SDA while SCL is high, between STOP_SETUP and STOP_SETUP+2 clocks after the last SCL rise. `done` then pulses for one cycle exactly HALF clocks later, at the same time as `busy` falls.
- R10: A start pulse while `busy` is high is ignored: no second START appears and the running transaction completes unchanged.
- R11: With `xfer_len` = 0 the block sends only the address byte and then a STOP, with no data handshake.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start | input | 1 | One-cycle request to launch a transaction (honoured only when idle) |
| dev_addr | input | 7 | Target address, captured at start |
| read_req | input | 1 | Direction: 1 = read, 0 = write, captured at start |
| xfer_len | input | LEN_W | Number of data bytes, captured at start |
| wr_data | input | 8 | Next byte to write |
| wr_valid | input | 1 | Write byte present |
| wr_ready | output | 1 | One-cycle request for the next write byte |
| rd_data | output | 8 | Last received byte |
| rd_valid | output | 1 | One-cycle pulse with each received byte |
| busy | output | 1 | Transaction in progress |
| done | output | 1 | One-cycle pulse at transaction end |
| nack_err | output | 1 | Target did not acknowledge in the last transaction |
| scl_out | output | 1 | Serial clock |
| sda_in | input | 1 | Sensed level of the SDA line |
| sda_pull | output | 1 | 1 pulls SDA low; 0 releases it |

## Verification
The assertions take three things for granted about the inputs:
- A write source always holds `wr_valid` high when `wr_ready` pulses.
- The target changes SDA only while SCL is low and never stretches the clock.
- `sda_in` follows the wired-AND of both drivers.

The bench keeps within these limits in three ways:
- Its write source keeps a byte presented at all times and advances only after a completed handshake.
- Its open-drain target model changes its pull one nanosecond after each SCL falling edge.
- Its SDA line is the inverse of the OR of the two pull signals.

// File: rtl/i2cm_pkg.sv
`timescale 1ns/1ps
package i2cm_pkg;
  typedef enum logic [2:0] {
    ST_IDLE,
    ST_START,
    ST_BITS,
    ST_STOP_LOW,
    ST_STOP_SETUP,
    ST_GAP
  } seq_state_t;
endpackage

// File: rtl/i2cm_scl_div.sv
`timescale 1ns/1ps
module i2cm_scl_div #(
  parameter int HALF = 125
) (
  input  logic                      clk,
  input  logic                      rst_n,
  input  logic                      en,
  output logic                      scl,
  output logic [$clog2(HALF)-1:0]   cnt
);
  localparam int CW = $clog2(HALF);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt <= '0;
      scl <= 1'b1;
    end else if (!en) begin
      cnt <= '0;
      scl <= 1'b1;
    end else if (cnt == CW'(HALF - 1)) begin
      cnt <= '0;
      scl <= ~scl;
    end else begin
      cnt <= cnt + 1'b1;
    end
  end

  // R3
  scl_half_period_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(en) && !$stable(scl)) |-> ($past(cnt) == CW'(HALF - 1)));

  // R3
  scl_rest_high_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !en |=> scl);
endmodule

// File: rtl/i2cm_line_sync.sv
`timescale 1ns/1ps
module i2cm_line_sync (
  input  logic clk,
  input  logic rst_n,
  input  logic sda_raw,
  input  logic scl_int,
  output logic sda_s,
  output logic scl_lvl,
  output logic scl_rise,
  output logic scl_fall
);
  logic sda_meta;
  logic scl_prev;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sda_meta <= 1'b1;
      sda_s    <= 1'b1;
      scl_lvl  <= 1'b1;
      scl_prev <= 1'b1;
    end else begin
      sda_meta <= sda_raw;
      sda_s    <= sda_meta;
      scl_lvl  <= scl_int;
      scl_prev <= scl_lvl;
    end
  end

  assign scl_rise = scl_lvl & ~scl_prev;
  assign scl_fall = ~scl_lvl & scl_prev;

  // R3
  scl_edge_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
    scl_rise |=> !scl_rise);
endmodule

// File: rtl/i2cm_seq.sv
`timescale 1ns/1ps
module i2cm_seq
  import i2cm_pkg::*;
#(
  parameter int HALF       = 125,
  parameter int START_HOLD = 60,
  parameter int STOP_SETUP = 60,
  parameter int LEN_W      = 4
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic                    start,
  input  logic [6:0]              dev_addr,
  input  logic                    read_req,
  input  logic [LEN_W-1:0]        xfer_len,
  input  logic [7:0]              wr_data,
  input  logic                    wr_valid,
  output logic                    wr_ready,
  output logic [7:0]              rd_data,
  output logic                    rd_valid,
  output logic                    busy,
  output logic                    done,
  output logic                    nack_err,
  input  logic                    sda_s,
  input  logic                    scl_lvl,
  input  logic                    scl_rise,
  input  logic                    scl_fall,
  input  logic [$clog2(HALF)-1:0] cnt,
  output logic                    div_en,
  output logic                    pull
);
  localparam int CW       = $clog2(HALF);
  localparam int HOLD_CNT = HALF / 4;
  localparam int SMP_CNT  = HALF / 2;
  localparam int WW       = $clog2(HALF + START_HOLD + STOP_SETUP + 1);

  seq_state_t       st;
  logic [7:0]       sh;
  logic [3:0]       bitn;
  logic [LEN_W-1:0] rem;
  logic             rd_mode, addr_ph, seen_fall;
  logic [WW-1:0]    wcnt;

  logic lowtick, hightick, rdbyte, byte_end;
  assign lowtick  = !scl_lvl && (cnt == CW'(HOLD_CNT));
  assign hightick = scl_lvl && (cnt == CW'(SMP_CNT)) && seen_fall;
  assign rdbyte   = rd_mode && !addr_ph;
  assign byte_end = (st == ST_BITS) && hightick && bitn[3];
  assign wr_ready = byte_end && !rd_mode && !sda_s && (rem != '0);
  assign busy     = (st != ST_IDLE);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st <= ST_IDLE; sh <= '0; bitn <= '0; rem <= '0;
      rd_mode <= 1'b0; addr_ph <= 1'b0; seen_fall <= 1'b0; wcnt <= '0;
      div_en <= 1'b0; pull <= 1'b0; done <= 1'b0; nack_err <= 1'b0;
      rd_data <= '0; rd_valid <= 1'b0;
    end else begin
      done     <= 1'b0;
      rd_valid <= 1'b0;
      case (st)
        ST_IDLE: if (start) begin
          sh <= {dev_addr, read_req}; rd_mode <= read_req; rem <= xfer_len;
          addr_ph <= 1'b1; bitn <= '0; nack_err <= 1'b0; pull <= 1'b1;
          wcnt <= '0; st <= ST_START;
        end
        ST_START: begin
          if (wcnt == WW'(START_HOLD - 1)) begin
            div_en <= 1'b1; seen_fall <= 1'b0; st <= ST_BITS;
          end else wcnt <= wcnt + 1'b1;
        end
        ST_BITS: begin
          if (scl_fall) seen_fall <= 1'b1;
          if (lowtick)
            pull <= bitn[3] ? (rdbyte && rem != LEN_W'(1)) : (!rdbyte && !sh[7]);
          if (hightick) begin
            if (!bitn[3]) begin
              sh   <= {sh[6:0], sda_s};
              bitn <= bitn + 1'b1;
              if (bitn == 4'd7 && rdbyte) begin
                rd_data <= {sh[6:0], sda_s}; rd_valid <= 1'b1;
              end
            end else begin
              bitn <= '0;
              if (rdbyte) begin
                rem <= rem - 1'b1;
                if (rem == LEN_W'(1)) st <= ST_STOP_LOW;
              end else if (sda_s) begin
                nack_err <= 1'b1; st <= ST_STOP_LOW;
              end else begin
                addr_ph <= 1'b0;
                if (rem == '0) st <= ST_STOP_LOW;
                else if (!rd_mode) begin sh <= wr_data; rem <= rem - 1'b1; end
              end
            end
          end
        end
        ST_STOP_LOW: begin
          if (lowtick) pull <= 1'b1;
          if (scl_rise && pull) begin div_en <= 1'b0; wcnt <= '0; st <= ST_STOP_SETUP; end
        end
        ST_STOP_SETUP: begin
          if (wcnt == WW'(STOP_SETUP - 1)) begin pull <= 1'b0; wcnt <= '0; st <= ST_GAP; end
          else wcnt <= wcnt + 1'b1;
        end
        ST_GAP: begin
          if (wcnt == WW'(HALF - 1)) begin st <= ST_IDLE; done <= 1'b1; end
          else wcnt <= wcnt + 1'b1;
        end
        default: st <= ST_IDLE;
      endcase
    end
  end

  // R4
  sda_release_high_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ($fell(pull) && scl_lvl) |-> (st == ST_GAP));

  // R7
  nack_to_stop_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(nack_err) |-> (st == ST_STOP_LOW));

  // R9
  done_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);

  // R6
  wr_source_chk: assert property (@(posedge clk) disable iff (!rst_n)
    wr_ready |-> wr_valid);
endmodule

// File: rtl/i2c_byte_master.sv
`timescale 1ns/1ps
module i2c_byte_master #(
  parameter int HALF       = 125,
  parameter int START_HOLD = 60,
  parameter int STOP_SETUP = 60,
  parameter int LEN_W      = 4
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             start,
  input  logic [6:0]       dev_addr,
  input  logic             read_req,
  input  logic [LEN_W-1:0] xfer_len,
  input  logic [7:0]       wr_data,
  input  logic             wr_valid,
  output logic             wr_ready,
  output logic [7:0]       rd_data,
  output logic             rd_valid,
  output logic             busy,
  output logic             done,
  output logic             nack_err,
  output logic             scl_out,
  input  logic             sda_in,
  output logic             sda_pull
);
  localparam int CW = $clog2(HALF);

  logic          div_en, sda_s, scl_lvl, scl_rise, scl_fall;
  logic [CW-1:0] cnt;

  i2cm_scl_div #(.HALF(HALF)) u_div (
    .clk(clk), .rst_n(rst_n), .en(div_en), .scl(scl_out), .cnt(cnt)
  );

  i2cm_line_sync u_sync (
    .clk(clk), .rst_n(rst_n), .sda_raw(sda_in), .scl_int(scl_out),
    .sda_s(sda_s), .scl_lvl(scl_lvl), .scl_rise(scl_rise), .scl_fall(scl_fall)
  );

  i2cm_seq #(.HALF(HALF), .START_HOLD(START_HOLD), .STOP_SETUP(STOP_SETUP),
             .LEN_W(LEN_W)) u_seq (
    .clk(clk), .rst_n(rst_n), .start(start), .dev_addr(dev_addr),
    .read_req(read_req), .xfer_len(xfer_len), .wr_data(wr_data),
    .wr_valid(wr_valid), .wr_ready(wr_ready), .rd_data(rd_data),
    .rd_valid(rd_valid), .busy(busy), .done(done), .nack_err(nack_err),
    .sda_s(sda_s), .scl_lvl(scl_lvl), .scl_rise(scl_rise), .scl_fall(scl_fall),
    .cnt(cnt), .div_en(div_en), .pull(sda_pull)
  );

  // R2
  start_only_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ($rose(sda_pull) && scl_out && $past(scl_out)) |-> $past(!busy));
endmodule

// File: tb/test_i2c_byte_master.sv
`timescale 1ns/1ps
module test_i2c_byte_master;
  localparam int CLK_PERIOD = 10;
  localparam int HALF = 8, SHOLD = 3, SSETUP = 4, LEN_W = 4;
  localparam logic [6:0] SLV = 7'h52;

  logic clk = 0, rst_n = 0, start = 0, read_req = 0, wr_valid = 1;
  logic [6:0] dev_addr = '0;
  logic [LEN_W-1:0] xfer_len = '0;
  logic [7:0] wr_data = '0, rd_data;
  logic wr_ready, rd_valid, busy, done, nack_err, scl_out, sda_pull;
  logic slv_pull = 0;
  wire  sda_line = ~(sda_pull | slv_pull);

  always #(CLK_PERIOD/2) clk = ~clk;

  i2c_byte_master #(.HALF(HALF), .START_HOLD(SHOLD), .STOP_SETUP(SSETUP), .LEN_W(LEN_W))
    i_i2c_byte_master (.clk(clk), .rst_n(rst_n), .start(start), .dev_addr(dev_addr),
    .read_req(read_req), .xfer_len(xfer_len), .wr_data(wr_data), .wr_valid(wr_valid),
    .wr_ready(wr_ready), .rd_data(rd_data), .rd_valid(rd_valid), .busy(busy),
    .done(done), .nack_err(nack_err), .scl_out(scl_out), .sda_in(sda_line),
    .sda_pull(sda_pull));

  int checks = 0, errors = 0;
  bit finished = 0;

  function automatic logic [7:0] wr_pat(input int i); return 8'h5A + 8'(i * 29); endfunction
  function automatic logic [7:0] rd_pat(input int i); return 8'hC3 ^ 8'(i * 37); endfunction

  task automatic check(input bit ok, input string tag, input string what,
                       input longint act, input longint exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s: actual=%0d expected=%0d", tag, what, act, exp);
    end
  endtask

  // bus monitors
  int starts, stops, scl_bad;
  time t_start, t_first_fall, t_last_rise, t_stop, t_done;
  bit rise_ok, fall_ok, first_fall;
  always @(negedge sda_line) if (scl_out === 1'b1) begin
    starts++; t_start = $time; rise_ok = 0; fall_ok = 0; first_fall = 1;
  end
  always @(posedge sda_line) if (scl_out === 1'b1 && busy === 1'b1) begin
    stops++; t_stop = $time;
  end
  always @(negedge scl_out) begin
    if (first_fall) begin t_first_fall = $time; first_fall = 0; end
    if (rise_ok && ($time - t_last_rise) != HALF * CLK_PERIOD) scl_bad++;
    fall_ok = 1; rise_ok = 0;
  end
  always @(posedge scl_out) begin
    if (fall_ok && ($time - t_first_fall) > 0 && ($time - t_stop) > 0) begin
      // low-phase width
    end
    t_last_rise = $time;
    rise_ok = fall_ok;
    fall_ok = 0;
  end
  time t_fall_q;
  always @(negedge scl_out) t_fall_q = $time;
  always @(posedge scl_out) if (busy === 1'b1 && ($time - t_fall_q) != HALF * CLK_PERIOD
                                && t_fall_q > t_start) scl_bad++;
  always @(posedge done) t_done = $time;

  // open-drain target model
  int s_bit = -1, s_byte = 0, s_wn = 0;
  logic [7:0] s_sh, s_addr, cur_rd, s_wlog[16];
  bit s_aack, s_rphase, s_mack[16];
  always @(negedge sda_line) if (scl_out === 1'b1) begin
    s_bit = -1; s_byte = 0; s_wn = 0; s_rphase = 0;
  end
  always @(posedge sda_line) if (scl_out === 1'b1) slv_pull = 0;
  always @(posedge scl_out) begin
    if (s_bit >= 0 && s_bit < 8) s_sh = {s_sh[6:0], sda_line};
    else if (s_bit == 8 && s_rphase && s_byte >= 1) s_mack[s_byte-1] = !sda_line;
  end
  always @(negedge scl_out) begin
    int nxt;
    #1;
    nxt = (s_bit == 8) ? 0 : s_bit + 1;
    if (nxt == 8) begin
      if (s_byte == 0) begin
        s_addr = s_sh; s_aack = (s_sh[7:1] == SLV); slv_pull = s_aack; s_rphase = 0;
      end else if (!s_addr[0]) begin
        s_wlog[s_wn] = s_sh; s_wn++; slv_pull = 1;
      end else slv_pull = 0;
    end else if (nxt == 0) begin
      if (s_bit == 8) s_byte++;
      if (s_byte >= 1 && s_addr[0] && s_aack && (s_byte == 1 || s_mack[s_byte-2])) begin
        cur_rd = rd_pat(s_byte - 1); s_rphase = 1; slv_pull = ~cur_rd[7];
      end else begin s_rphase = 0; slv_pull = 0; end
    end else slv_pull = s_rphase ? ~cur_rd[7-nxt] : 1'b0;
    s_bit = nxt;
  end

  // stream source and sink
  int widx, wr_hs, rn;
  logic [7:0] rlog[16];
  bit take;
  always @(negedge clk) begin
    if (take) begin widx++; wr_data = wr_pat(widx); end
    take = wr_ready && wr_valid;
    if (take) wr_hs++;
    if (rd_valid) begin rlog[rn] = rd_data; rn++; end
  end

  task automatic run_txn(input logic [6:0] a, input logic r, input int n, input bit extra);
    starts = 0; stops = 0; scl_bad = 0; widx = 0; wr_hs = 0; rn = 0; take = 0;
    wr_data = wr_pat(0);
    @(negedge clk); dev_addr = a; read_req = r; xfer_len = LEN_W'(n); start = 1;
    @(negedge clk); start = 0;
    if (extra) begin
      repeat (40) @(negedge clk);
      dev_addr = ~a; read_req = ~r; start = 1;
      @(negedge clk); start = 0;
    end
    for (int i = 0; i < 30000 && !done; i++) @(negedge clk);
    check(done === 1'b1, "R9", "done seen", done, 1);
    check(busy === 1'b0, "R9", "busy low with done", busy, 0);
    @(negedge clk);
    check(done === 1'b0, "R9", "done one cycle", done, 0);
    check(starts == 1 && stops == 1, "R4", "one START and one STOP", starts * 10 + stops, 11);
    check(scl_bad == 0, "R3", "SCL half periods", scl_bad, 0);
    check(t_first_fall - t_start == (SHOLD + HALF) * CLK_PERIOD, "R2", "START hold",
          t_first_fall - t_start, (SHOLD + HALF) * CLK_PERIOD);
    check(t_stop - t_last_rise >= SSETUP * CLK_PERIOD &&
          t_stop - t_last_rise <= (SSETUP + 2) * CLK_PERIOD, "R9", "STOP setup",
          t_stop - t_last_rise, SSETUP * CLK_PERIOD);
    check(t_done - t_stop == HALF * CLK_PERIOD, "R9", "bus free before done",
          t_done - t_stop, HALF * CLK_PERIOD);
    check(s_addr == {a, r}, "R5", "address byte", s_addr, {a, r});
  endtask

  task automatic t_reset;
    check(scl_out === 1 && sda_pull === 0, "R1", "idle lines", {scl_out, sda_pull}, 2);
    check(busy === 0 && done === 0 && nack_err === 0, "R1", "idle status",
          {busy, done, nack_err}, 0);
  endtask

  task automatic t_write;
    run_txn(SLV, 0, 3, 0);
    check(wr_hs == 3, "R6", "write handshakes", wr_hs, 3);
    check(s_wn == 3, "R6", "bytes on wire", s_wn, 3);
    for (int i = 0; i < 3; i++)
      check(s_wlog[i] == wr_pat(i), "R6", "write byte", s_wlog[i], wr_pat(i));
    check(nack_err === 0, "R7", "no error on ACK", nack_err, 0);
  endtask

  task automatic t_read(input int n);
    run_txn(SLV, 1, n, 0);
    check(rn == n, "R8", "rd_valid pulses", rn, n);
    for (int i = 0; i < n; i++) begin
      check(rlog[i] == rd_pat(i), "R8", "read byte", rlog[i], rd_pat(i));
      check(s_mack[i] == (i < n - 1), "R8", "master ACK/NACK", s_mack[i], i < n - 1);
    end
  endtask

  task automatic t_nack;
    run_txn(7'h11, 0, 2, 0);
    check(nack_err === 1, "R7", "nack_err set", nack_err, 1);
    check(wr_hs == 0 && s_wn == 0, "R7", "no data after NACK", wr_hs + s_wn, 0);
    repeat (20) @(negedge clk);
    check(nack_err === 1, "R7", "nack_err held", nack_err, 1);
  endtask

  task automatic t_zero_len;
    run_txn(SLV, 0, 0, 0);
    check(wr_hs == 0, "R11", "no handshake for length 0", wr_hs, 0);
    run_txn(SLV, 1, 0, 0);
    check(rn == 0, "R11", "no read bytes for length 0", rn, 0);
  endtask

  task automatic t_busy_start;
    run_txn(SLV, 0, 1, 1);
    check(s_wn == 1 && s_wlog[0] == wr_pat(0), "R10", "transfer unchanged", s_wlog[0], wr_pat(0));
    repeat (50) @(negedge clk);
    check(busy === 0 && starts == 1, "R10", "ignored start left no activity", starts, 1);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    t_reset;
    rst_n = 1;
    repeat (3) @(negedge clk);
    t_reset;
    t_write;
    t_read(3);
    t_read(1);
    t_nack;
    t_zero_len;
    t_busy_start;
    if (!finished) begin
      finished = 1;
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!finished) begin
      finished = 1;
      checks++; errors++;
      $display("FAIL watchdog: actual=timeout expected=completion");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end
endmodule